// File: doc/BRIEF.md
# Strobe-Gated Parallel Capture Port

This block takes in 16-bit words from an external parallel converter. It makes a sample clock for that converter by dividing the system clock by a programmable amount and drives that clock out on a pin. On the sample-clock edge that the configuration selects, rising or falling, the block takes the word on its data pins. When gating is on, it takes the word only while the external strobe is high. Captured words go into a small first-in first-out buffer. A downstream consumer drains the buffer with a valid/ready handshake.

Everything runs on the system clock. The sample clock is a registered divider output, and a capture happens on the system-clock edge at which that output changes in the selected direction. The strobe is asynchronous to the block, so it passes through a two-stage synchronizer before it can qualify a capture. A single write port loads the divider, the edge selection and the gating flag together. Each write also restarts the sample clock and empties the buffer.

Top module: `strobe_cap_port`

## Requirements
- R1: After reset the sample clock output is 0, out_valid is 0 and overflow is 0. The divider resets to 0, so the clock is halted. Gating resets to on and the edge selection resets to rising.
- R2: With a divider value N > 0, the sample clock output is high for N system clocks and then low for N system clocks. Its period is therefore 2·N system clocks.
- R3: A divider value of 0 holds the sample clock output low, and nothing is captured.
- R4: With cfg_edge_fall = 0, a word is captured on each system-clock edge at which the sample clock output goes from 0 to 1. The word captured is the value on adc_data at that edge.
- R5: With cfg_edge_fall = 1, a word is captured on each system-clock edge at which the sample clock output goes from 1 to 0.
- R6: With cfg_gate_en = 1, a selected edge captures only if the strobe was high at the system-clock edge two cycles earlier, which is the two-stage synchronizer delay. A strobe held low captures nothing.
- R7: With cfg_gate_en = 0, every selected edge captures, whatever the strobe level.
- R8: Every qualifying edge captures, even when adc_data has not changed, so a held value appears once per qualifying edge.
- R9: The buffer holds 4 words and delivers them in capture order. A word leaves on a system-clock edge where out_valid and out_ready are both 1. While out_valid is 1 and out_ready is 0, out_data holds steady.
- R10: A capture that arrives while the buffer is full and nothing leaves on the same edge is dropped, and overflow is set. Overflow stays at 1 until the next configuration write.
- R11: A cycle with cfg_we = 1 does all of the following:
  - loads the three configuration fields;
  - empties the buffer and clears overflow;
  - resets the divider counter and drives the sample clock output to 0;
  - captures nothing on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_div | input | 12 | Divider value; half-period of the sample clock in system clocks |
| cfg_edge_fall | input | 1 | 1 selects falling-edge capture, 0 selects rising-edge capture |
| cfg_gate_en | input | 1 | 1 makes capture depend on the strobe |
| adc_data | input | 16 | Parallel data from the converter |
| adc_strobe | input | 1 | Asynchronous capture enable from outside |
| smp_clk_out | output | 1 | Generated sample clock for the converter |
| out_valid | output | 1 | Buffer holds at least one word |
| out_ready | input | 1 | Consumer accepts the word on out_data |
| out_data | output | 16 | Oldest buffered word |
| overflow | output | 1 | Sticky flag: a capture was lost because the buffer was full |

## Verification
The scoreboard predicts every capture independently from the edges of the sample clock output and from the strobe as it stood two cycles earlier. A design that sampled the strobe with the wrong latency, or captured on the unselected edge, would therefore show up as a word mismatch or an unexpected extra word. The bench measures the high and low phases of the sample clock at two divider values, which catches an off-by-one in the divider terminal count. It also fills the buffer with the consumer stalled, to check the following:
- that the fifth capture is dropped and not written over an older word;
- that overflow stays set after the buffer is drained;
- that a configuration write empties the buffer and clears the flag.

It also holds the data constant while the strobe is high, to confirm that repeated values are captured once per edge and never merged.

// File: rtl/strobe_cap_pkg.sv
package strobe_cap_pkg;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } scp_edge_e;

   function automatic logic scp_pick_edge(scp_edge_e sel, logic rise_evt, logic fall_evt);
      return (sel == EDGE_FALL) ? fall_evt : rise_evt;
   endfunction

endpackage

// File: rtl/scp_clkgen.sv
module scp_clkgen #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             smp_clk,
   output logic             rise_evt,
   output logic             fall_evt
);

   if (DIV_W < 1) begin : g_bad_width
      $error("scp_clkgen: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] cnt_q;
   logic             clk_q;
   logic             run;
   logic             wrap;

   assign run  = (div != '0);
   assign wrap = run && (cnt_q == div - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         clk_q <= 1'b0;
      end else if (restart || !run) begin
         cnt_q <= '0;
         clk_q <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         clk_q <= ~clk_q;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

   assign smp_clk  = clk_q;
   assign rise_evt = wrap && !restart && !clk_q;
   assign fall_evt = wrap && !restart &&  clk_q;

   AST_HALT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (div == '0) |=> !smp_clk) else $error("halted divider let clock rise"); // R3
   AST_RISE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      rise_evt |=> smp_clk) else $error("rise event without clock high"); // R4
   AST_FALL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      fall_evt |=> !smp_clk) else $error("fall event without clock low"); // R5

endmodule

// File: rtl/scp_sync.sv
module scp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("scp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[0] <= 1'b0;
            else        q[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= q[i-1];
         end
      end
   end

   assign dout = q[STAGES-1];

endmodule

// File: rtl/scp_fifo.sv
module scp_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic         rvalid,
   output logic [W-1:0] rdata,
   output logic         drop
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("scp_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("scp_fifo: W must be at least 1");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          full, do_pop, accept;

   function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
   endfunction

   assign full   = (cnt == CW'(DEPTH));
   assign rvalid = (cnt != '0);
   assign do_pop = rvalid && pop;
   assign accept = push && (!full || do_pop);
   assign drop   = push && full && !do_pop;
   assign rdata  = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (accept) wp <= ptr_next(wp);
         if (do_pop) rp <= ptr_next(rp);
         case ({accept, do_pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (accept && !flush) mem[wp] <= wdata;
   end

   AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH)) else $error("fifo count beyond depth"); // R9
   AST_FIFO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rvalid && !pop && !flush) |=> (rvalid && $stable(rdata))) else $error("head moved while stalled"); // R9

endmodule

// File: rtl/strobe_cap_port.sv
module strobe_cap_port
   import strobe_cap_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int DIV_W       = 12,
   parameter int FIFO_DEPTH  = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              cfg_edge_fall,
   input  logic              cfg_gate_en,
   input  logic [DATA_W-1:0] adc_data,
   input  logic              adc_strobe,
   output logic              smp_clk_out,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              overflow
);

   if (DATA_W < 1) begin : g_bad_data_w
      $error("strobe_cap_port: DATA_W must be at least 1");
   end

   logic [DIV_W-1:0] div_q;
   scp_edge_e        edge_q;
   logic             gate_q;
   logic             rise_evt, fall_evt;
   logic             stb_sync;
   logic             capture;
   logic             drop;
   logic             ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         edge_q <= EDGE_RISE;
         gate_q <= 1'b1;
      end else if (cfg_we) begin
         div_q  <= cfg_div;
         edge_q <= scp_edge_e'(cfg_edge_fall);
         gate_q <= cfg_gate_en;
      end
   end

   scp_clkgen #(.DIV_W(DIV_W)) u_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (cfg_we),
      .div      (div_q),
      .smp_clk  (smp_clk_out),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt)
   );

   scp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (adc_strobe),
      .dout  (stb_sync)
   );

   assign capture = !cfg_we
                  && scp_pick_edge(edge_q, rise_evt, fall_evt)
                  && (!gate_q || stb_sync);

   scp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (cfg_we),
      .push   (capture),
      .wdata  (adc_data),
      .pop    (out_ready),
      .rvalid (out_valid),
      .rdata  (out_data),
      .drop   (drop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ovf_q <= 1'b0;
      else if (cfg_we) ovf_q <= 1'b0;
      else if (drop)   ovf_q <= 1'b1;
   end

   assign overflow = ovf_q;

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !cfg_we) |=> overflow) else $error("overflow flag cleared early"); // R10
   AST_CFG_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (!out_valid && !overflow && !smp_clk_out)) else $error("config write did not reset state"); // R11
   AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((div_q == '0) && !out_valid && !cfg_we) |=> !out_valid) else $error("capture while divider halted"); // R3

endmodule

// File: tb/strobe_cap_port_bench.sv
`timescale 1ns/1ps
module strobe_cap_port_bench;
   localparam int DW = 16;
   localparam int VW = 12;
   localparam int DEPTH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          cfg_we = 1'b0;
   logic [VW-1:0] cfg_div = '0;
   logic          cfg_edge_fall = 1'b0;
   logic          cfg_gate_en = 1'b0;
   logic [DW-1:0] adc_data = '0;
   logic          adc_strobe = 1'b0;
   logic          out_ready = 1'b0;
   wire           smp_clk_out, out_valid, overflow;
   wire  [DW-1:0] out_data;

   strobe_cap_port u_strobe_cap_port (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div),
      .cfg_edge_fall(cfg_edge_fall), .cfg_gate_en(cfg_gate_en),
      .adc_data(adc_data), .adc_strobe(adc_strobe), .smp_clk_out(smp_clk_out),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .overflow(overflow)
   );

   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // stimulus driver: data and strobe change 1 ns after each rising edge
   logic data_hold = 1'b0;
   int   stb_mode = 0;
   logic stb_static = 1'b0;
   initial begin
      int t;
      t = 0;
      forever begin
         @(posedge clk); #1;
         t++;
         if (!data_hold) adc_data = adc_data + 16'h0133;
         adc_strobe = (stb_mode == 1) ? ((t % 7) < 3) : stb_static;
      end
   end

   // what the design sees at each rising edge
   logic [DW-1:0] s_data = '0;
   logic s_stb1 = 0, s_stb2 = 0, s_stb3 = 0, s_cfg = 0;
   logic m_fall = 0, m_gate = 1;
   always @(posedge clk) begin
      s_data <= adc_data;
      s_stb1 <= adc_strobe;
      s_stb2 <= s_stb1;
      s_stb3 <= s_stb2;
      s_cfg  <= cfg_we;
      if (cfg_we) begin
         m_fall <= cfg_edge_fall;
         m_gate <= cfg_gate_en;
      end
   end

   // predictor + scoreboard monitor
   logic [DW-1:0] sb_q[$];
   logic prev_clk = 0;
   logic exp_ovf = 0;
   int n_edge = 0, n_capt = 0, n_pop = 0, n_dup = 0;
   logic [DW-1:0] last_pop = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (s_cfg) begin
            sb_q.delete();
            exp_ovf = 0;
            prev_clk = 0;
         end else begin
            if (m_fall ? (prev_clk && !smp_clk_out) : (!prev_clk && smp_clk_out)) begin
               n_edge++;
               if (!m_gate || s_stb3) begin
                  n_capt++;
                  if (sb_q.size() < DEPTH) sb_q.push_back(s_data);
                  else exp_ovf = 1;
               end
            end
            prev_clk = smp_clk_out;
         end
         if (out_valid && out_ready) begin
            if (sb_q.size() == 0) begin
               chk(0, "R9 unexpected word", int'(out_data), -1);
            end else begin
               logic [DW-1:0] e;
               e = sb_q.pop_front();
               chk(out_data == e, "R4/R5/R6/R9 scoreboard word", int'(out_data), int'(e));
            end
            if (n_pop > 0 && out_data == last_pop) n_dup++;
            last_pop = out_data;
            n_pop++;
         end
      end
   end

   task automatic write_cfg(input int div, input bit fall, input bit gate);
      @(posedge clk); #1;
      cfg_div = VW'(div); cfg_edge_fall = fall; cfg_gate_en = gate; cfg_we = 1'b1;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic measure(input int div);
      int hi, lo;
      do @(negedge clk); while (smp_clk_out !== 1'b0);
      do @(negedge clk); while (smp_clk_out !== 1'b1);
      hi = 0;
      while (smp_clk_out === 1'b1) begin hi++; @(negedge clk); end
      lo = 0;
      while (smp_clk_out === 1'b0) begin lo++; @(negedge clk); end
      chk(hi == div, "R2 high phase", hi, div);
      chk(lo == div, "R2 low phase", lo, div);
   endtask

   initial begin
      int c0, e0, viol;
      idle(4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(smp_clk_out == 0, "R1 clock after reset", smp_clk_out, 0);
      chk(out_valid == 0, "R1 valid after reset", out_valid, 0);
      chk(overflow == 0, "R1 overflow after reset", overflow, 0);
      idle(1);

      // R2 / R4 / R7: rising edge, gating off
      out_ready = 1'b1;
      write_cfg(3, 0, 0);
      measure(3);
      c0 = n_capt; e0 = n_edge;
      idle(60);
      chk(n_capt - c0 >= 8, "R4 rising captures", n_capt - c0, 8);
      chk(n_capt - c0 == n_edge - e0, "R7 every edge captured", n_capt - c0, n_edge - e0);
      write_cfg(200, 0, 0);
      measure(200);

      // R5: falling edge
      write_cfg(2, 1, 0);
      c0 = n_capt;
      idle(40);
      chk(n_capt - c0 >= 8, "R5 falling captures", n_capt - c0, 8);

      // R6: gated with a toggling strobe
      stb_mode = 1;
      write_cfg(1, 0, 1);
      c0 = n_capt; e0 = n_edge;
      idle(84);
      chk(n_capt - c0 > 0, "R6 some captured", n_capt - c0, 1);
      chk(n_capt - c0 < n_edge - e0, "R6 some blocked", n_capt - c0, n_edge - e0);
      // R6: strobe held low
      stb_mode = 0; stb_static = 1'b0;
      idle(6);
      c0 = n_pop;
      idle(40);
      @(negedge clk);
      chk(n_pop == c0, "R6 nothing with strobe low", n_pop - c0, 0);
      chk(out_valid == 0, "R6 buffer empty with strobe low", out_valid, 0);

      // R7: gating off ignores a low strobe
      write_cfg(1, 0, 0);
      c0 = n_pop;
      idle(40);
      chk(n_pop - c0 >= 15, "R7 captures with strobe low", n_pop - c0, 15);

      // R8: held data captured on every edge
      data_hold = 1'b1; stb_static = 1'b1;
      write_cfg(1, 0, 1);
      idle(5);
      c0 = n_capt; e0 = n_edge; viol = n_dup;
      idle(30);
      chk(n_capt - c0 == n_edge - e0, "R8 capture per edge", n_capt - c0, n_edge - e0);
      chk(n_dup - viol >= 10, "R8 repeated value kept", n_dup - viol, 10);
      data_hold = 1'b0;

      // R3: divider zero
      write_cfg(0, 0, 0);
      idle(3);
      viol = 0;
      repeat (40) begin
         @(negedge clk);
         if (smp_clk_out !== 1'b0 || out_valid !== 1'b0) viol++;
      end
      chk(viol == 0, "R3 halted clock and no capture", viol, 0);

      // R9 / R10: stall consumer and overflow
      out_ready = 1'b0;
      write_cfg(1, 0, 0);
      idle(24);
      @(negedge clk);
      chk(overflow == 1, "R10 overflow set", overflow, 1);
      chk(overflow == exp_ovf, "R10 overflow as predicted", overflow, exp_ovf);
      chk(sb_q.size() == DEPTH, "R9 four words held", sb_q.size(), DEPTH);
      idle(1);
      out_ready = 1'b1;
      idle(12);
      @(negedge clk);
      chk(overflow == 1, "R10 overflow sticky after drain", overflow, 1);

      // R11: config write empties buffer and clears flag
      idle(1);
      out_ready = 1'b0;
      idle(6);
      @(negedge clk);
      chk(out_valid == 1, "R11 buffer filled before write", out_valid, 1);
      write_cfg(5, 0, 0);
      @(negedge clk);
      chk(out_valid == 0, "R11 buffer emptied", out_valid, 0);
      chk(overflow == 0, "R11 overflow cleared", overflow, 0);
      chk(smp_clk_out == 0, "R11 clock restarted low", smp_clk_out, 0);
      idle(1);
      out_ready = 1'b1;
      measure(5);
      idle(20);
      chk(sb_q.size() <= 1, "R9 scoreboard drained", sb_q.size(), 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      #4000000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule